// File: doc/BRIEF.md
# Debug return branch calculator

This block follows the program counter of a processor core while the core is halted in debug state. From that count it builds the branch that resumes normal execution. A single-cycle entry pulse opens a debug session and carries a two-bit cause code. Each instruction the core executes while halted is reported by a pulse that also says whether it ran at debug speed or at system speed. The debugger then raises a return request, and the block answers with the branch offset in words, the same distance in bytes (for a PC-subtract form of short return), a ready-made always-taken branch instruction, and a 33-bit scan word that holds a flag bit above that instruction.

The advance that has built up is the base added at entry, plus one for every debug-speed instruction, plus three for every system-speed instruction. The return branch itself counts as one debug-speed instruction. The branch offset is the negative of that sum. If the return is requested before two instructions have run, the block rejects the request, raises an error pulse and stays in debug state.

Top module: `dbg_ret_calc`

## Requirements
- R1: The entry base is 4 for cause codes 0 (breakpoint) and 1 (watchpoint). It is 3 for cause codes 2 (external halt request) and 3 (watchpoint coinciding with an exception).
- R2: Each debug-speed instruction pulse (`instr_sys`=0) in debug state adds 1 to the total. The accepted return branch adds 1 more.
- R3: Each system-speed instruction pulse (`instr_sys`=1) in debug state adds 3 to the total.
- R4: On a result, `word_off` is the 24-bit two's complement of the total. `branch_word` is 0xEA in bits 31:24 with `word_off` in bits 23:0. `scan_word` is `branch_word` with bit 32 (the flag) at 0. For example, a total of 7 gives 0xEAFFFFF9.
- R5: On a result, `byte_off` equals 4 times the total (7 words give 28).
- R6: A return request in debug state with fewer than two instructions counted gives a one-cycle `too_few_err`, gives no `res_valid`, leaves every result output unchanged and keeps `in_debug` at 1.
- R7: An entry pulse clears both counts, latches the new base and sets `in_debug`, even when already in debug state. In that cycle it takes precedence over an instruction pulse or a return request.
- R8: Instruction pulses and return requests while `in_debug` is 0 have no effect: nothing is counted, and no result or error appears.
- R9: An instruction pulse in the same cycle as an accepted return request is counted in that result and in the two-instruction minimum.
- R10: Each count saturates at 2^CNT_W-1. `ovf` is set on a result when a count has saturated or the total exceeds 2^23.
- R11: Results are registered and appear one clock after the request with a one-cycle `res_valid`. `in_debug` drops in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_valid | input | 1 | Debug entry pulse |
| entry_cause | input | 2 | Entry cause code (0..3) |
| instr_valid | input | 1 | Instruction executed in debug state |
| instr_sys | input | 1 | 1 = system-speed, 0 = debug-speed |
| ret_req | input | 1 | Request the final return branch |
| res_valid | output | 1 | One-cycle result strobe |
| word_off | output | 24 | Signed word offset of the branch |
| byte_off | output | CNT_W+5 | Positive byte distance (4 x total) |
| branch_word | output | 32 | Always-taken branch instruction |
| scan_word | output | 33 | Flag bit 32 followed by the branch |
| too_few_err | output | 1 | Request rejected: fewer than two instructions |
| ovf | output | 1 | Count saturated or offset out of range |
| in_debug | output | 1 | Debug session open |

## Verification
An instruction pulse and the return request can arrive in the same cycle. The block must count that instruction in the total and also use it to meet the two-instruction minimum. The bench drives one instruction, then a second debug-speed instruction together with the request. It expects a valid result with total 7 for a breakpoint and no error. A second case pairs a system-speed instruction with the request and expects the extra 3. A third collision, entry arriving together with an instruction, is judged by the total of the following return.

// File: rtl/dbg_ret_pkg.sv
// Package: shared types and constants for the debug return calculator.
// Assumes the cause code is two bits wide and the branch field is 24 bits.
package dbg_ret_pkg;
    typedef enum logic [1:0] {
        CAUSE_BKPT      = 2'd0,
        CAUSE_WATCH     = 2'd1,
        CAUSE_HALTREQ   = 2'd2,
        CAUSE_WATCH_EXC = 2'd3
    } entry_cause_e;

    localparam int          OFF_W     = 24;
    localparam logic [7:0]  BR_OPCODE = 8'hEA;

    // Entry base in addresses for a given cause
    function automatic logic [2:0] base_for_cause(input entry_cause_e c);
        return (c == CAUSE_BKPT || c == CAUSE_WATCH) ? 3'd4 : 3'd3;
    endfunction
endpackage

// File: rtl/dbg_ret_sat_cnt.sv
// Saturating up-counter with synchronous clear.
// Also provides the next value and a sticky "clipped" flag, which is set
// when an increment is requested while the counter is at its maximum.
// Assumes clear has priority over increment.
module dbg_ret_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_nxt,
    output logic         clip_nxt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         clip_q;

    // Compute next count and clip state
    always_comb begin
        if (clr) begin
            cnt_nxt  = '0;
            clip_nxt = 1'b0;
        end else if (inc) begin
            cnt_nxt  = (cnt_q == MAXV) ? cnt_q : cnt_q + W'(1);
            clip_nxt = clip_q | (cnt_q == MAXV);
        end else begin
            cnt_nxt  = cnt_q;
            clip_nxt = clip_q;
        end
    end

    // Register count and clip state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            clip_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            clip_q <= clip_nxt;
        end
    end
endmodule

// File: rtl/dbg_ret_tracker.sv
// Session tracker: holds the debug-state flag and the latched entry base,
// and counts debug-speed and system-speed instructions.
// Assumes entry takes precedence over instructions and return in its cycle.
// The outputs are next-state values, so that an instruction in the same
// cycle as the return is included in the result.
module dbg_ret_tracker
    import dbg_ret_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_valid,
    input  entry_cause_e     entry_cause,
    input  logic             instr_valid,
    input  logic             instr_sys,
    input  logic             ret_accept,
    output logic             in_dbg,
    output logic [2:0]       base,
    output logic [CNT_W-1:0] n_nxt,
    output logic [CNT_W-1:0] s_nxt,
    output logic             clip_nxt
);
    logic count_en;
    logic clip_n, clip_s;

    assign count_en = in_dbg && !entry_valid && instr_valid;
    assign clip_nxt = clip_n | clip_s;

    dbg_ret_sat_cnt #(.W(CNT_W)) u_cnt_dbg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (entry_valid),
        .inc      (count_en && !instr_sys),
        .cnt_nxt  (n_nxt),
        .clip_nxt (clip_n)
    );

    dbg_ret_sat_cnt #(.W(CNT_W)) u_cnt_sys (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (entry_valid),
        .inc      (count_en && instr_sys),
        .cnt_nxt  (s_nxt),
        .clip_nxt (clip_s)
    );

    // Track debug state and latch the entry base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_dbg <= 1'b0;
            base   <= 3'd4;
        end else if (entry_valid) begin
            in_dbg <= 1'b1;
            base   <= base_for_cause(entry_cause);
        end else if (ret_accept) begin
            in_dbg <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_ret_encoder.sv
// Combinational encoder: total advance = base + N + 1 + 3S, turned into a
// negative 24-bit word offset, a byte distance, and a branch opcode word.
// Assumes CNT_W <= 29 so that the total fits a 32-bit compare.
module dbg_ret_encoder
    import dbg_ret_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [2:0]       base,
    input  logic [CNT_W-1:0] n_cnt,
    input  logic [CNT_W-1:0] s_cnt,
    input  logic             clip,
    output logic [OFF_W-1:0] word_off,
    output logic [CNT_W+4:0] byte_off,
    output logic [31:0]      branch_word,
    output logic             ovf
);
    localparam int TOT_W = CNT_W + 3;

    logic [TOT_W-1:0] total;
    logic [31:0]      total32;
    logic [31:0]      neg32;

    // Sum the entry base, debug instructions, branch and system accesses
    always_comb begin
        total = TOT_W'(base) + {3'b000, n_cnt} + TOT_W'(1)
              + {2'b00, s_cnt, 1'b0} + {3'b000, s_cnt};
        total32     = 32'(total);
        neg32       = 32'd0 - total32;
        word_off    = neg32[OFF_W-1:0];
        byte_off    = {total, 2'b00};
        branch_word = {BR_OPCODE, word_off};
        ovf         = clip || (total32 > 32'h0080_0000);
    end
endmodule

// File: rtl/dbg_ret_calc.sv
// Top of the debug return branch calculator.
// Accepts a return request only in debug state, with no entry in the same
// cycle and with at least two instructions counted. Otherwise the request
// raises the error pulse (in debug state) or is ignored (outside it).
// All outputs are registered; results change only alongside res_valid.
module dbg_ret_calc
    import dbg_ret_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_valid,
    input  logic [1:0]       entry_cause,
    input  logic             instr_valid,
    input  logic             instr_sys,
    input  logic             ret_req,
    output logic             res_valid,
    output logic [23:0]      word_off,
    output logic [CNT_W+4:0] byte_off,
    output logic [31:0]      branch_word,
    output logic [32:0]      scan_word,
    output logic             too_few_err,
    output logic             ovf,
    output logic             in_debug
);
    logic             in_dbg;
    logic [2:0]       base;
    logic [CNT_W-1:0] n_nxt, s_nxt;
    logic             clip_nxt;
    logic             ret_try, too_few, ret_ok;
    logic [CNT_W:0]   instr_sum;
    logic [23:0]      enc_word;
    logic [CNT_W+4:0] enc_byte;
    logic [31:0]      enc_branch;
    logic             enc_ovf;

    assign ret_try   = ret_req && in_dbg && !entry_valid;
    assign instr_sum = {1'b0, n_nxt} + {1'b0, s_nxt};
    assign too_few   = ret_try && (instr_sum < (CNT_W+1)'(2));
    assign ret_ok    = ret_try && !too_few;
    assign in_debug  = in_dbg;

    dbg_ret_tracker #(.CNT_W(CNT_W)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_valid (entry_valid),
        .entry_cause (entry_cause_e'(entry_cause)),
        .instr_valid (instr_valid),
        .instr_sys   (instr_sys),
        .ret_accept  (ret_ok),
        .in_dbg      (in_dbg),
        .base        (base),
        .n_nxt       (n_nxt),
        .s_nxt       (s_nxt),
        .clip_nxt    (clip_nxt)
    );

    dbg_ret_encoder #(.CNT_W(CNT_W)) u_encoder (
        .base        (base),
        .n_cnt       (n_nxt),
        .s_cnt       (s_nxt),
        .clip        (clip_nxt),
        .word_off    (enc_word),
        .byte_off    (enc_byte),
        .branch_word (enc_branch),
        .ovf         (enc_ovf)
    );

    // Strobes: result valid and too-few error, one cycle each
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            too_few_err <= 1'b0;
        end else begin
            res_valid   <= ret_ok;
            too_few_err <= too_few;
        end
    end

    // Result registers, loaded only on an accepted return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_off    <= '0;
            byte_off    <= '0;
            branch_word <= '0;
            scan_word   <= '0;
            ovf         <= 1'b0;
        end else if (ret_ok) begin
            word_off    <= enc_word;
            byte_off    <= enc_byte;
            branch_word <= enc_branch;
            scan_word   <= {1'b0, enc_branch};
            ovf         <= enc_ovf;
        end
    end
endmodule

// File: rtl/dbg_ret_calc_chk.sv
// Checker for dbg_ret_calc: port-level temporal properties, bound to the top.
// Assumes it sees the same clock and synchronous active-low reset.
module dbg_ret_calc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             entry_valid,
    input logic             ret_req,
    input logic             res_valid,
    input logic [23:0]      word_off,
    input logic [CNT_W+4:0] byte_off,
    input logic [31:0]      branch_word,
    input logic [32:0]      scan_word,
    input logic             too_few_err,
    input logic             ovf,
    input logic             in_debug
);
    logic [23:0] mag;
    assign mag = 24'd0 - word_off;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11
    AST_EXIT_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_debug); // R11
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && too_few_err)); // R6
    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        too_few_err |-> in_debug); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(branch_word) && $stable(byte_off)); // R6
    AST_BRANCH_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> branch_word[31:24] == 8'hEA && branch_word[23:0] == word_off
                      && scan_word == {1'b0, branch_word}); // R4
    AST_BYTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !ovf) |-> 32'(byte_off) == {6'b0, mag, 2'b00}); // R5
    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_debug && !entry_valid) |=> !res_valid && !too_few_err && !in_debug); // R8
    AST_ENTRY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && !ret_req) |=> in_debug && !res_valid); // R7
endmodule

bind dbg_ret_calc dbg_ret_calc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_valid (entry_valid),
    .ret_req     (ret_req),
    .res_valid   (res_valid),
    .word_off    (word_off),
    .byte_off    (byte_off),
    .branch_word (branch_word),
    .scan_word   (scan_word),
    .too_few_err (too_few_err),
    .ovf         (ovf),
    .in_debug    (in_debug)
);

// File: tb/dbg_ret_calc_tb.sv
// Directed bench for dbg_ret_calc, one task per scenario.
module dbg_ret_calc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          entry_valid = 1'b0;
    logic [1:0]    entry_cause = 2'd0;
    logic          instr_valid = 1'b0;
    logic          instr_sys = 1'b0;
    logic          ret_req = 1'b0;
    logic          res_valid;
    logic [23:0]   word_off;
    logic [CW+4:0] byte_off;
    logic [31:0]   branch_word;
    logic [32:0]   scan_word;
    logic          too_few_err, ovf, in_debug;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_ret_calc #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .entry_valid(entry_valid),
        .entry_cause(entry_cause), .instr_valid(instr_valid),
        .instr_sys(instr_sys), .ret_req(ret_req), .res_valid(res_valid),
        .word_off(word_off), .byte_off(byte_off), .branch_word(branch_word),
        .scan_word(scan_word), .too_few_err(too_few_err), .ovf(ovf),
        .in_debug(in_debug)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, registered outputs visible at next negedge
    task automatic step(input logic e, input logic [1:0] c, input logic iv,
                        input logic is, input logic r);
        entry_valid = e; entry_cause = c; instr_valid = iv; instr_sys = is; ret_req = r;
        @(posedge clk);
        @(negedge clk);
        entry_valid = 0; instr_valid = 0; instr_sys = 0; ret_req = 0;
    endtask

    task automatic enter(input logic [1:0] c);  step(1, c, 0, 0, 0); endtask
    task automatic dinstr();                    step(0, 0, 1, 0, 0); endtask
    task automatic sinstr();                    step(0, 0, 1, 1, 0); endtask
    task automatic ret();                       step(0, 0, 0, 0, 1); endtask

    // Check a full result against an expected total advance
    task automatic check_result(input string req, input int total, input logic exp_ovf);
        logic [23:0] w;
        w = 24'(-total);
        check({req, " res_valid"}, 64'(res_valid), 64'd1);
        check({req, " word_off"}, 64'(word_off), 64'(w));
        check({req, " branch_word"}, 64'(branch_word), 64'({8'hEA, w}));
        check({req, " scan_word"}, 64'(scan_word), 64'({1'b0, 8'hEA, w}));
        check({req, " byte_off R5"}, 64'(byte_off), 64'((CW+5)'(total*4)));
        check({req, " ovf R10"}, 64'(ovf), 64'(exp_ovf));
        check({req, " in_debug R11"}, 64'(in_debug), 64'd0);
    endtask

    task automatic t_reset();
        check("reset res_valid", 64'(res_valid), 0);
        check("reset in_debug", 64'(in_debug), 0);
        check("reset too_few_err", 64'(too_few_err), 0);
        check("reset branch_word", 64'(branch_word), 0);
    endtask

    task automatic t_breakpoint();  // R1 R2 R4: 4+2+1 = 7 -> EAFFFFF9
        enter(2'd0);
        check("R7 in_debug after entry", 64'(in_debug), 1);
        dinstr(); dinstr(); ret();
        check_result("R1 R2 R4 breakpoint", 7, 0);
        check("R4 example word", 64'(branch_word), 64'h EAFF_FFF9);
        check("R5 example bytes", 64'(byte_off), 28);
        @(negedge clk);
        check("R11 res_valid single cycle", 64'(res_valid), 0);
    endtask

    task automatic t_haltreq();      // R1: 3+2+1 = 6 -> EAFFFFFA
        enter(2'd2);
        dinstr(); dinstr(); ret();
        check_result("R1 halt request", 6, 0);
        check("R1 example word", 64'(branch_word), 64'h EAFF_FFFA);
    endtask

    task automatic t_watch_exc();    // R1: 3+12+1 = 16 -> EAFFFFF0
        enter(2'd3);
        for (int i = 0; i < 12; i++) dinstr();
        ret();
        check_result("R1 watch+exception", 16, 0);
        check("R1 example word -16", 64'(branch_word), 64'h EAFF_FFF0);
    endtask

    task automatic t_system();       // R3: 4 + 1 + 1 + 2*3 = 12
        enter(2'd1);
        sinstr(); dinstr(); sinstr(); ret();
        check_result("R3 system speed", 12, 0);
    endtask

    task automatic t_too_few();      // R6
        logic [31:0] prev;
        prev = branch_word;
        enter(2'd0);
        dinstr(); ret();
        check("R6 too_few_err", 64'(too_few_err), 1);
        check("R6 no res_valid", 64'(res_valid), 0);
        check("R6 output held", 64'(branch_word), 64'(prev));
        check("R6 still in debug", 64'(in_debug), 1);
        dinstr(); ret();
        check_result("R6 retry after error", 7, 0);
    endtask

    task automatic t_outside();      // R8
        logic [31:0] prev;
        prev = branch_word;
        dinstr(); sinstr(); dinstr(); ret();
        check("R8 no result outside debug", 64'(res_valid), 0);
        check("R8 no error outside debug", 64'(too_few_err), 0);
        check("R8 outputs unchanged", 64'(branch_word), 64'(prev));
        check("R8 in_debug stays low", 64'(in_debug), 0);
        enter(2'd2);
        dinstr(); dinstr(); ret();
        check_result("R8 earlier pulses not counted", 6, 0);
    endtask

    task automatic t_same_cycle();   // R9
        enter(2'd0);
        dinstr();
        step(0, 0, 1, 0, 1);
        check("R9 no error with same-cycle instr", 64'(too_few_err), 0);
        check_result("R9 debug instr with return", 7, 0);
        enter(2'd1);
        dinstr();
        step(0, 0, 1, 1, 1);
        check_result("R9 system instr with return", 9, 0);
    endtask

    task automatic t_reentry();      // R7
        enter(2'd0);
        for (int i = 0; i < 5; i++) sinstr();
        step(1, 2'd2, 1, 0, 0);        // entry wins over same-cycle instr
        dinstr(); dinstr();
        step(1, 2'd3, 0, 0, 1);        // entry wins over same-cycle return
        check("R7 return ignored with entry", 64'(res_valid), 0);
        check("R7 still in debug", 64'(in_debug), 1);
        dinstr(); dinstr(); ret();
        check_result("R7 re-entry clears counts", 6, 0);
    endtask

    task automatic t_saturate();     // R10: 33 debug instrs, count saturates at 31
        enter(2'd0);
        for (int i = 0; i < 33; i++) dinstr();
        ret();
        check("R10 res_valid", 64'(res_valid), 1);
        check("R10 ovf on saturation", 64'(ovf), 1);
        enter(2'd0);
        dinstr(); dinstr(); ret();
        check_result("R10 ovf clears on new session", 7, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_breakpoint();
        t_haltreq();
        t_watch_exc();
        t_system();
        t_too_few();
        t_outside();
        t_same_cycle();
        t_reentry();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule